// File: doc/BRIEF.md
# Configuration Space Register Responder

This block answers byte-wide configuration reads and writes for a single-function bus target. A host side presents a function number, an 8-bit register offset, a write strobe and a write byte each cycle. The block returns the addressed byte one clock later. It holds a fixed identity, a two-bit command register, an interrupt line byte and one I/O base address register that claims a 32-byte window.

From the command and base registers it derives a registered I/O window base and an enable flag. A downstream port-address decoder uses these two outputs to claim I/O cycles. The slot number where the target sits is fed in on an input port and appears in the byte normally used for a revision code. The identity bytes are parameters.

Top module: `cfg_space_responder`

## Requirements
- R1: Only function number 0 is decoded; with any other function number a read returns 0xFF and a write changes nothing.
- R2: Offsets 0x00, 0x01, 0x02, 0x03 read 0x1A, 0x07, 0x0B, 0xAB (vendor code 0x071A, device code 0xAB0B, low byte first), and offsets 0x2C to 0x2F return the same four bytes in the same order.
- R3: A write to offset 0x04 stores only bits 1:0, and a read of 0x04 returns those two bits with bits 7:2 zero; bit 0 is the I/O space enable.
- R4: A write to offset 0x10 stores only bits 7:5, and a read of 0x10 returns those bits with bits 4:1 zero and bit 0 set to 1; offset 0x11 stores and returns all eight bits.
- R5: Offset 0x08 returns the `slot_id` input, and offset 0x3D always reads 0x01.
- R6: Offset 0x3C is a plain eight-bit read/write byte.
- R7: Offsets 0x05 to 0x07, 0x0A and 0x0B read their held value, which is zero and not writable. Every other offset not named in R2 to R6 reads 0x00 and ignores writes.
- R8: Read data for a request presented in one cycle appears on `cfg_rdata` after the next rising edge. A read presented in the cycle right after a write returns the newly written value.
- R9: `io_base` equals {byte 0x11, bits 7:5 of the base register, five zero bits}, so its low five bits are always zero. `io_en` is 1 exactly when command bit 0 is 1 and that base is nonzero.
- R10: Both `io_base` and `io_en` are registered. They show a write's effect one rising edge after the edge that stores the write, and not at that edge itself.
- R11: A synchronous active-low reset clears every stored register, `cfg_rdata`, `io_base` and `io_en` to zero at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_func | input | FUNC_W | Function number of the access |
| cfg_off | input | 8 | Register byte offset |
| cfg_we | input | 1 | Write strobe |
| cfg_wdata | input | 8 | Write byte |
| slot_id | input | 8 | Slot number returned at offset 0x08 |
| cfg_rdata | output | 8 | Read byte, one cycle after the request |
| io_base | output | 16 | Decoded 32-byte aligned I/O window base |
| io_en | output | 1 | I/O window claim enable |

## Verification
The read byte comes from a register loaded at the edge that ends the request cycle. The bench drives each request on a falling edge and compares `cfg_rdata` at the following falling edge against a model updated by every write that came before. The I/O outputs lag the register state by one more edge. The bench therefore checks them one full cycle after a write's falling edge, and it also confirms that they still hold their old value at the falling edge right after the write.

// File: rtl/cfg_pkg.sv
// Package of shared constants for the configuration space responder.
// Assumes byte-wide registers and an 8-bit offset space.
package cfg_pkg;
    localparam int BYTE_W = 8;
    localparam int OFF_W  = 8;

    localparam logic [OFF_W-1:0] OFF_CMD   = 8'h04;
    localparam logic [OFF_W-1:0] OFF_SLOT  = 8'h08;
    localparam logic [OFF_W-1:0] OFF_BASEL = 8'h10;
    localparam logic [OFF_W-1:0] OFF_BASEH = 8'h11;
    localparam logic [OFF_W-1:0] OFF_ILINE = 8'h3C;
    localparam logic [OFF_W-1:0] OFF_IPIN  = 8'h3D;

    // Pick one byte of the 32-bit identity word, low byte first.
    function automatic logic [BYTE_W-1:0] ident_byte(input logic [31:0] word,
                                                    input logic [1:0]  idx);
        return word[idx*BYTE_W +: BYTE_W];
    endfunction
endpackage

// File: rtl/cfg_regs.sv
// Writable configuration state: command bits, base address fields and
// interrupt line byte. Assumes writes target function 0 only.
module cfg_regs
    import cfg_pkg::*;
#(
    parameter int FUNC_W     = 3,
    parameter int ALIGN_BITS = 5,
    localparam int LO_W      = BYTE_W - ALIGN_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FUNC_W-1:0] func,
    input  logic [OFF_W-1:0]  off,
    input  logic              we,
    input  logic [BYTE_W-1:0] wdata,
    output logic [1:0]        cmd,
    output logic [LO_W-1:0]   base_lo,
    output logic [BYTE_W-1:0] base_hi,
    output logic [BYTE_W-1:0] iline
);
    logic wr_hit;

    // Write qualifies only for function 0.
    assign wr_hit = we && (func == '0);

    // Store the writable fields; every other offset drops the write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd     <= '0;
            base_lo <= '0;
            base_hi <= '0;
            iline   <= '0;
        end else if (wr_hit) begin
            case (off)
                OFF_CMD:   cmd     <= wdata[1:0];
                OFF_BASEL: base_lo <= wdata[BYTE_W-1:ALIGN_BITS];
                OFF_BASEH: base_hi <= wdata;
                OFF_ILINE: iline   <= wdata;
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/cfg_rd_mux.sv
// Combinational read selection across the offset space.
// Assumes ALIGN_BITS >= 2 so that the I/O marker bit fits below the kept field.
module cfg_rd_mux
    import cfg_pkg::*;
#(
    parameter int          FUNC_W     = 3,
    parameter int          ALIGN_BITS = 5,
    parameter logic [31:0] IDENT      = 32'hAB0B_071A,
    parameter logic [7:0]  IRQ_PIN    = 8'h01,
    localparam int         LO_W       = BYTE_W - ALIGN_BITS
) (
    input  logic [FUNC_W-1:0] func,
    input  logic [OFF_W-1:0]  off,
    input  logic [BYTE_W-1:0] slot_id,
    input  logic [1:0]        cmd,
    input  logic [LO_W-1:0]   base_lo,
    input  logic [BYTE_W-1:0] base_hi,
    input  logic [BYTE_W-1:0] iline,
    output logic [BYTE_W-1:0] rd_byte
);
    // Select the byte for the current offset; unknown functions float high.
    always_comb begin
        rd_byte = '0;
        if (func != '0) begin
            rd_byte = '1;
        end else begin
            case (off)
                8'h00, 8'h01, 8'h02, 8'h03,
                8'h2C, 8'h2D, 8'h2E, 8'h2F: rd_byte = ident_byte(IDENT, off[1:0]);
                OFF_CMD:   rd_byte = {{(BYTE_W-2){1'b0}}, cmd};
                OFF_SLOT:  rd_byte = slot_id;
                OFF_BASEL: rd_byte = {base_lo, {(ALIGN_BITS-1){1'b0}}, 1'b1};
                OFF_BASEH: rd_byte = base_hi;
                OFF_ILINE: rd_byte = iline;
                OFF_IPIN:  rd_byte = IRQ_PIN;
                default:   rd_byte = '0;
            endcase
        end
    end
endmodule

// File: rtl/cfg_io_dec.sv
// Registered I/O window base and enable derived from stored state.
// Assumes the base register is already stripped of its alignment bits.
module cfg_io_dec
    import cfg_pkg::*;
#(
    parameter int  ALIGN_BITS = 5,
    localparam int LO_W       = BYTE_W - ALIGN_BITS,
    localparam int BASE_W     = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_space_on,
    input  logic [LO_W-1:0]   base_lo,
    input  logic [BYTE_W-1:0] base_hi,
    output logic [BASE_W-1:0] io_base,
    output logic              io_en
);
    logic [BASE_W-1:0] base_nx;

    // Assemble the aligned base from its stored fields.
    assign base_nx = {base_hi, base_lo, {ALIGN_BITS{1'b0}}};

    // Register the window so the decoder sees a clean flop output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            io_base <= '0;
            io_en   <= 1'b0;
        end else begin
            io_base <= base_nx;
            io_en   <= io_space_on && (base_nx != '0);
        end
    end
endmodule

// File: rtl/cfg_space_responder.sv
// Top of the configuration space responder: write storage, read select with
// one registered stage, and I/O window decode. Single function only.
module cfg_space_responder
    import cfg_pkg::*;
#(
    parameter int          FUNC_W     = 3,
    parameter int          ALIGN_BITS = 5,
    parameter logic [31:0] IDENT      = 32'hAB0B_071A,
    parameter logic [7:0]  IRQ_PIN    = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FUNC_W-1:0] cfg_func,
    input  logic [7:0]        cfg_off,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_wdata,
    input  logic [7:0]        slot_id,
    output logic [7:0]        cfg_rdata,
    output logic [15:0]       io_base,
    output logic              io_en
);
    localparam int LO_W = BYTE_W - ALIGN_BITS;

    logic [1:0]        cmd;
    logic [LO_W-1:0]   base_lo;
    logic [BYTE_W-1:0] base_hi;
    logic [BYTE_W-1:0] iline;
    logic [BYTE_W-1:0] rd_byte;

    cfg_regs #(.FUNC_W(FUNC_W), .ALIGN_BITS(ALIGN_BITS)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .func   (cfg_func),
        .off    (cfg_off),
        .we     (cfg_we),
        .wdata  (cfg_wdata),
        .cmd    (cmd),
        .base_lo(base_lo),
        .base_hi(base_hi),
        .iline  (iline)
    );

    cfg_rd_mux #(.FUNC_W(FUNC_W), .ALIGN_BITS(ALIGN_BITS),
                 .IDENT(IDENT), .IRQ_PIN(IRQ_PIN)) u_mux (
        .func   (cfg_func),
        .off    (cfg_off),
        .slot_id(slot_id),
        .cmd    (cmd),
        .base_lo(base_lo),
        .base_hi(base_hi),
        .iline  (iline),
        .rd_byte(rd_byte)
    );

    cfg_io_dec #(.ALIGN_BITS(ALIGN_BITS)) u_io (
        .clk        (clk),
        .rst_n      (rst_n),
        .io_space_on(cmd[0]),
        .base_lo    (base_lo),
        .base_hi    (base_hi),
        .io_base    (io_base),
        .io_en      (io_en)
    );

    // Hold the selected byte for one cycle as the read response.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_rdata <= '0;
        else        cfg_rdata <= rd_byte;
    end
endmodule

// File: rtl/cfg_space_chk.sv
// Checker for the configuration space responder, bound to its top.
// Assumes default identity and interrupt pin values.
module cfg_space_chk #(
    parameter int FUNC_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [FUNC_W-1:0] cfg_func,
    input logic [7:0]        cfg_off,
    input logic [7:0]        slot_id,
    input logic [7:0]        cfg_rdata,
    input logic [15:0]       io_base,
    input logic              io_en
);
    // R1
    func_other_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_func != '0) |=> (cfg_rdata == 8'hFF));

    // R2
    ident_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_func == '0 && cfg_off == 8'h00) |=> (cfg_rdata == 8'h1A));

    // R3
    cmd_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_func == '0 && cfg_off == 8'h04) |=> (cfg_rdata[7:2] == 6'd0));

    // R4
    base_io_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_func == '0 && cfg_off == 8'h10) |=> (cfg_rdata[4:0] == 5'b00001));

    // R5
    slot_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_func == '0 && cfg_off == 8'h08) |=> (cfg_rdata == $past(slot_id)));

    // R5
    irq_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_func == '0 && cfg_off == 8'h3D) |=> (cfg_rdata == 8'h01));

    // R9
    en_needs_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_en |-> (io_base != 16'h0000));

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        (!rst_n) |=> (cfg_rdata == 8'h00 && io_base == 16'h0000 && !io_en));
endmodule

bind cfg_space_responder cfg_space_chk #(.FUNC_W(FUNC_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_func (cfg_func),
    .cfg_off  (cfg_off),
    .slot_id  (slot_id),
    .cfg_rdata(cfg_rdata),
    .io_base  (io_base),
    .io_en    (io_en)
);

// File: tb/tb_cfg_space_responder.sv
`timescale 1ns/1ps
// Bench for the configuration space responder: directed corners plus
// seeded random traffic checked against a bench-side model.
module tb_cfg_space_responder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_func = '0;
    logic [7:0]  cfg_off = '0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  slot_id = 8'h05;
    logic [7:0]  cfg_rdata;
    logic [15:0] io_base;
    logic        io_en;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    // model state
    logic [1:0] m_cmd = '0;
    logic [7:0] m_blo = '0;
    logic [7:0] m_bhi = '0;
    logic [7:0] m_il  = '0;

    cfg_space_responder dut (
        .clk(clk), .rst_n(rst_n), .cfg_func(cfg_func), .cfg_off(cfg_off),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .slot_id(slot_id),
        .cfg_rdata(cfg_rdata), .io_base(io_base), .io_en(io_en)
    );

    always #2.5 clk = ~clk;

    function automatic logic [7:0] exp_rd(input logic [2:0] f, input logic [7:0] o);
        if (f != 3'd0) return 8'hFF;
        case (o)
            8'h00, 8'h2C: return 8'h1A;
            8'h01, 8'h2D: return 8'h07;
            8'h02, 8'h2E: return 8'h0B;
            8'h03, 8'h2F: return 8'hAB;
            8'h04: return {6'd0, m_cmd};
            8'h08: return slot_id;
            8'h10: return (m_blo & 8'hE0) | 8'h01;
            8'h11: return m_bhi;
            8'h3C: return m_il;
            8'h3D: return 8'h01;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [15:0] exp_base();
        return {m_bhi, m_blo & 8'hE0};
    endfunction

    function automatic logic exp_en();
        return m_cmd[0] && (exp_base() != 16'h0000);
    endfunction

    function automatic logic [7:0] pick_off();
        logic [7:0] tbl [20] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06,
                                 8'h07, 8'h08, 8'h0A, 8'h0B, 8'h10, 8'h11, 8'h2C,
                                 8'h2D, 8'h2E, 8'h2F, 8'h3C, 8'h3D, 8'h20};
        if ($urandom % 4 == 0) return 8'($urandom);
        return tbl[$urandom % 20];
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [2:0] f, input logic [7:0] o, input logic [7:0] d);
        @(negedge clk);
        cfg_func = f; cfg_off = o; cfg_wdata = d; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        if (f == 3'd0) begin
            case (o)
                8'h04: m_cmd = d[1:0];
                8'h10: m_blo = d & 8'hE0;
                8'h11: m_bhi = d;
                8'h3C: m_il  = d;
                default: ;
            endcase
        end
    endtask

    task automatic do_read(input string req, input logic [2:0] f, input logic [7:0] o);
        logic [7:0] e;
        @(negedge clk);
        cfg_we = 1'b0; cfg_func = f; cfg_off = o;
        e = exp_rd(f, o);
        @(negedge clk);
        check(req, {8'h00, cfg_rdata}, {8'h00, e});
    endtask

    task automatic check_io(input string req);
        @(negedge clk);
        check(req, io_base, exp_base());
        check(req, {15'd0, io_en}, {15'd0, exp_en()});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_cmd = '0; m_blo = '0; m_bhi = '0; m_il = '0;
        check("R11 rdata", {8'h00, cfg_rdata}, 16'h0000);
        check("R11 io_base", io_base, 16'h0000);
        check("R11 io_en", {15'd0, io_en}, 16'h0000);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(5.0 * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [15:0] old_base;
        logic        old_en;
        void'($urandom(32'd4242));
        // first cycles in reset
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R11 rdata after reset", {8'h00, cfg_rdata}, 16'h0000);
        check("R11 io_en after reset", {15'd0, io_en}, 16'h0000);
        do_read("R11 cmd zero", 3'd0, 8'h04);
        do_read("R11 base low zero", 3'd0, 8'h10);
        do_read("R11 iline zero", 3'd0, 8'h3C);

        // R2 identity bytes, both copies
        for (int i = 0; i < 4; i++) do_read("R2 ident", 3'd0, 8'(i));
        for (int i = 0; i < 4; i++) do_read("R2 subsystem ident", 3'd0, 8'(8'h2C + i));

        // R3 command masking
        do_write(3'd0, 8'h04, 8'hFF);
        do_read("R3 cmd keeps bits 1:0", 3'd0, 8'h04);

        // R4 base fields
        do_write(3'd0, 8'h10, 8'hFF);
        do_read("R4 base low masked", 3'd0, 8'h10);
        do_write(3'd0, 8'h11, 8'h12);
        do_read("R4 base high full", 3'd0, 8'h11);
        check_io("R9 window enabled");

        // R6 interrupt line, and R8 immediate read after write
        do_write(3'd0, 8'h3C, 8'hA5);
        do_read("R6 R8 iline readback", 3'd0, 8'h3C);

        // R5 slot and pin
        slot_id = 8'h1F;
        do_read("R5 slot echo", 3'd0, 8'h08);
        do_read("R5 irq pin", 3'd0, 8'h3D);

        // R1 other functions
        do_read("R1 func 3 reads FF", 3'd3, 8'h00);
        do_write(3'd2, 8'h3C, 8'h11);
        do_read("R1 foreign write ignored", 3'd0, 8'h3C);
        do_write(3'd7, 8'h04, 8'h00);
        check_io("R1 foreign write keeps window");

        // R7 read-only and unlisted offsets
        do_write(3'd0, 8'h05, 8'hFF);
        do_read("R7 offset 05 zero", 3'd0, 8'h05);
        do_write(3'd0, 8'h0B, 8'hFF);
        do_read("R7 offset 0B zero", 3'd0, 8'h0B);
        do_write(3'd0, 8'h20, 8'hFF);
        do_read("R7 unlisted zero", 3'd0, 8'h20);

        // R10 io outputs lag by one edge
        old_base = io_base; old_en = io_en;
        do_write(3'd0, 8'h04, 8'h00);
        check("R10 io_en not yet changed", {15'd0, io_en}, {15'd0, old_en});
        check_io("R10 io_en updated next edge");
        do_write(3'd0, 8'h11, 8'h80);
        check("R10 io_base not yet changed", io_base, old_base);
        check_io("R10 io_base updated next edge");

        // R9 zero base keeps window off
        do_write(3'd0, 8'h04, 8'h01);
        do_write(3'd0, 8'h10, 8'h00);
        do_write(3'd0, 8'h11, 8'h00);
        check_io("R9 zero base disables");
        do_write(3'd0, 8'h10, 8'h20);
        check_io("R9 smallest base enables");

        // R11 reset in mid-run
        do_reset();
        do_read("R11 iline cleared", 3'd0, 8'h3C);

        // random traffic
        for (int k = 0; k < 600; k++) begin
            logic [2:0] f;
            logic [7:0] o;
            f = ($urandom % 5 == 0) ? 3'($urandom) : 3'd0;
            o = pick_off();
            if ($urandom % 16 == 0) slot_id = 8'($urandom);
            if ($urandom % 2 == 0) begin
                do_write(f, o, 8'($urandom));
                if ($urandom % 3 == 0) check_io("R9 R10 random window");
            end else begin
                do_read("R8 random read", f, o);
            end
        end
        finish_run();
    end
endmodule